// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo serial audio stream, made of a bit clock, a frame clock and a data line, and turns it into pairs of parallel words. All three serial lines are oversampled by the fast system clock: they pass through a synchronizer, and each rising edge of the bit clock becomes a one-cycle bit event. Three line formats are accepted. In left-justified, the MSB starts on the frame change. In I2S, the MSB starts one bit clock later. In right-justified, the word ends just before the next frame change.

Every word comes out MSB-aligned in a 32-bit container. Left-justified and I2S words are always taken at full 32-bit length. Right-justified words are cut to a selectable depth of 16, 20 or 24 bits. When a half-frame carries fewer bit clocks than the word needs, the bits that did arrive fill the top of the word and the rest are zero. Nothing is added to the samples: no rounding and no dither. The left and right words are delivered together with a single valid pulse once the right half-frame has ended.

Top module: `sar_rx`

## Requirements
- R1: `fmt_i` selects the line format: 0 is left-justified, 1 is I2S, and 2 or 3 is right-justified (both codes behave identically).
- R2: In left-justified and right-justified formats, a high frame clock marks the left channel. In I2S, a low frame clock marks the left channel.
- R3: In left-justified format, the bit sampled on the first bit clock rise after a frame clock change is the MSB (word bit 31). The next bits follow in descending order. Bits after the 32nd in a half-frame are ignored.
- R4: In I2S format, the bit on the first bit clock rise after a frame clock change is the last bit of the previous word. The MSB of the new word comes one bit clock later. Up to 32 bits are kept.
- R5: In right-justified format, the word is the last N bits sampled before the frame clock change. The first bit sampled with the new frame level also belongs to the new half. N is 16, 20, 24 or 24 for `depth_i` = 0, 1, 2 or 3. The N bits are placed at word bits 31 down to 32-N, and the low 32-N bits are zero. Earlier bits are ignored.
- R6: A half-frame with fewer bit clocks than the word needs gives a word holding the received bits at the top and zeros below. In left-justified and I2S, this is k received bits. In right-justified, this is all k bits when k < N.
- R7: `valid_o` is a one-cycle pulse issued after a right half-frame completes. It presents that right word and the left word of the half-frame just before it. Both outputs hold their values between pulses.
- R8: The partial half-frame in progress when reset is released is discarded. A right half-frame with no captured left half before it produces no pulse.
- R9: While `rst` is high, and in the cycle after it, `valid_o` is low and both words are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial bit clock, sampled on its rising edge |
| fclk_i | input | 1 | Serial frame clock (channel select) |
| sdata_i | input | 1 | Serial data line |
| fmt_i | input | 2 | Line format select (R1) |
| depth_i | input | 2 | Right-justified word depth select (R5) |
| left_o | output | 32 | Left channel word, MSB-aligned |
| right_o | output | 32 | Right channel word, MSB-aligned |
| valid_o | output | 1 | One-cycle strobe marking a new stereo pair |

## Verification
The bench builds the receiver with its default 32-bit word and a two-stage synchronizer, and drives a bit clock at one sixth of the system clock. It sweeps every format code and every depth code, using half-frame lengths of 12, 16, 17, 24, 32 and 40 bit clocks. This covers full words, short frames and over-long frames. Padding bits are driven as ones, so any bit that leaks from outside the word window shows up. Each expected word is rebuilt arithmetically from the bit positions on the line.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    FMT_LEFT_JUST  = 2'd0,
    FMT_I2S        = 2'd1,
    FMT_RIGHT_JUST = 2'd2,
    FMT_RIGHT_ALT  = 2'd3
  } fmt_e;

  // Right-justified word length for a depth code (R5)
  function automatic int unsigned depth_len(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic fclk_i,
  input  logic sdata_i,
  output logic bit_evt,
  output logic frm,
  output logic dat
);

  localparam int LAST = STAGES - 1;

  logic [2:0] stage_q [STAGES];
  logic       sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      sclk_d <= 1'b0;
    end else begin
      stage_q[0] <= {sclk_i, fclk_i, sdata_i};
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      sclk_d <= stage_q[LAST][2];
    end
  end

  assign bit_evt = stage_q[LAST][2] & ~sclk_d;
  assign frm     = stage_q[LAST][1];
  assign dat     = stage_q[LAST][0];

endmodule

// File: rtl/sar_capture.sv
module sar_capture
  import sar_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_evt,
  input  logic              frm,
  input  logic              dat,
  input  logic [1:0]        fmt,
  input  logic [1:0]        depth,
  output logic              done,
  output logic              done_left,
  output logic [WORD_W-1:0] word
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic              have_prev, started, frm_prev;
  logic [WORD_W-1:0] acc, sr;
  logic [CNT_W-1:0]  cnt;

  logic              is_rj, is_i2s, edge_seen;
  logic [WORD_W-1:0] acc_app, sr_app, rj_word, fin_word;
  logic [CNT_W-1:0]  cnt_inc;
  int unsigned       keep_n, keep_m;

  always_comb begin
    is_rj     = fmt[1];
    is_i2s    = (fmt_e'(fmt) == FMT_I2S);
    edge_seen = have_prev && (frm != frm_prev);

    // left-aligned accumulation, first WORD_W bits only
    acc_app = acc;
    if (32'(cnt) < WORD_W) acc_app[WORD_W-1-32'(cnt)] = dat;
    cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;

    // right-justified: most recent bits, trimmed to depth
    sr_app = {sr[WORD_W-2:0], dat};
    keep_n = depth_len(depth);
    keep_m = (32'(cnt) < keep_n) ? 32'(cnt) : keep_n;
    rj_word = (keep_m == 0) ? '0 : (sr << (WORD_W - keep_m));

    if (is_rj)       fin_word = rj_word;
    else if (is_i2s) fin_word = acc_app;   // edge bit is the old word's last bit
    else             fin_word = acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev <= 1'b0;
      started   <= 1'b0;
      frm_prev  <= 1'b0;
      acc       <= '0;
      sr        <= '0;
      cnt       <= '0;
      done      <= 1'b0;
      done_left <= 1'b0;
      word      <= '0;
    end else begin
      done <= 1'b0;
      if (bit_evt) begin
        if (!have_prev) begin
          have_prev <= 1'b1;
          frm_prev  <= frm;
          acc       <= '0;
          sr        <= '0;
          cnt       <= '0;
        end else if (edge_seen) begin
          done      <= started;
          started   <= 1'b1;
          word      <= fin_word;
          done_left <= is_i2s ? ~frm_prev : frm_prev;
          frm_prev  <= frm;
          if (is_i2s) begin
            acc <= '0;
            sr  <= '0;
            cnt <= '0;
          end else begin
            acc <= {dat, {(WORD_W-1){1'b0}}};
            sr  <= {{(WORD_W-1){1'b0}}, dat};
            cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
          end
        end else begin
          acc <= acc_app;
          sr  <= sr_app;
          cnt <= cnt_inc;
        end
      end
    end
  end

endmodule

// File: rtl/sar_pair.sv
module sar_pair #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic              done_left,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);

  logic [WORD_W-1:0] left_hold;
  logic              have_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold <= '0;
      have_left <= 1'b0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (done) begin
        if (done_left) begin
          left_hold <= word;
          have_left <= 1'b1;
        end else if (have_left) begin
          left_o    <= left_hold;
          right_o   <= word;
          valid_o   <= 1'b1;
          have_left <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/sar_rx.sv
module sar_rx #(
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              fclk_i,
  input  logic              sdata_i,
  input  logic [1:0]        fmt_i,
  input  logic [1:0]        depth_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);

  localparam int CNT_W = $clog2(WORD_W + 1);

  logic              bit_evt, frm, dat;
  logic              cap_done, cap_left;
  logic [WORD_W-1:0] cap_word;

  sar_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .sclk_i  (sclk_i),
    .fclk_i  (fclk_i),
    .sdata_i (sdata_i),
    .bit_evt (bit_evt),
    .frm     (frm),
    .dat     (dat)
  );

  sar_capture #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .bit_evt   (bit_evt),
    .frm       (frm),
    .dat       (dat),
    .fmt       (fmt_i),
    .depth     (depth_i),
    .done      (cap_done),
    .done_left (cap_left),
    .word      (cap_word)
  );

  sar_pair #(.WORD_W(WORD_W)) u_pair (
    .clk       (clk),
    .rst       (rst),
    .done      (cap_done),
    .done_left (cap_left),
    .word      (cap_word),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o)
  );

endmodule

// File: rtl/sar_rx_chk.sv
module sar_rx_chk
  import sar_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   fmt_i,
  input logic [1:0]   depth_i,
  input logic         valid_o,
  input logic [W-1:0] left_o,
  input logic [W-1:0] right_o,
  input logic         cap_done,
  input logic         cap_left
);

  logic [W-1:0] low_mask;
  always_comb low_mask = {W{1'b1}} >> depth_len(depth_i);

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (left_o != $past(left_o) || right_o != $past(right_o)) |-> valid_o);

  p_after_right_r7: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(cap_done && !cap_left));

  p_rj_low_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_o && fmt_i[1]) |-> ((left_o & low_mask) == '0 && (right_o & low_mask) == '0));

  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!valid_o && left_o == '0 && right_o == '0));

endmodule

bind sar_rx sar_rx_chk #(.W(WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .fmt_i    (fmt_i),
  .depth_i  (depth_i),
  .valid_o  (valid_o),
  .left_o   (left_o),
  .right_o  (right_o),
  .cap_done (cap_done),
  .cap_left (cap_left)
);

// File: tb/tb_sar_rx.sv
module tb_sar_rx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0, fclk = 1'b0, sdat = 1'b0;
  logic [1:0]  fmt = 2'd0, depth = 2'd0;
  logic [31:0] left_o, right_o;
  logic        valid_o;

  always #2.5 clk = ~clk;

  sar_rx dut (
    .clk     (clk),
    .rst     (rst),
    .sclk_i  (sclk),
    .fclk_i  (fclk),
    .sdata_i (sdat),
    .fmt_i   (fmt),
    .depth_i (depth),
    .left_o  (left_o),
    .right_o (right_o),
    .valid_o (valid_o)
  );

  int n_chk = 0, n_fail = 0, n_got = 0, gen_idx = 0;
  int cur_nclk = 32, cur_nbits = 32;
  bit fin = 1'b0;
  logic [31:0] got_l [64];
  logic [31:0] got_r [64];
  logic [31:0] exp_l [8];
  logic [31:0] exp_r [8];

  always @(negedge clk) begin
    if (valid_o && n_got < 64) begin
      got_l[n_got] = left_o;
      got_r[n_got] = right_o;
      n_got++;
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic sbit(input logic [31:0] w, input int j);
    return (j < cur_nbits) ? w[31-j] : 1'b1;
  endfunction

  function automatic logic rjbit(input logic [31:0] w, input int i);
    int off = cur_nclk - cur_nbits;
    return (i >= off) ? w[31-(i-off)] : 1'b1;
  endfunction

  function automatic logic [31:0] expect_word(input logic [31:0] w);
    logic [31:0] r = '0;
    if (fmt[1]) begin
      int n = (depth == 2'd0) ? 16 : (depth == 2'd1) ? 20 : 24;
      int m = (cur_nclk < n) ? cur_nclk : n;
      for (int j = 0; j < m; j++) r[31-j] = rjbit(w, cur_nclk - m + j);
    end else begin
      int m = (cur_nclk < 32) ? cur_nclk : 32;
      for (int j = 0; j < m; j++) r[31-j] = sbit(w, j);
    end
    return r;
  endfunction

  function automatic logic [31:0] gen();
    logic [31:0] a = 32'h9E3779B9 * 32'(gen_idx + 7);
    gen_idx++;
    return a ^ (32'h00FF00FF << (gen_idx % 8));
  endfunction

  task automatic drive_bit(input logic lvl, input logic b);
    @(negedge clk);
    sclk = 1'b0; fclk = lvl; sdat = b;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_half(input logic lvl, input logic [31:0] cur, input logic [31:0] prevw);
    for (int i = 0; i < cur_nclk; i++) begin
      logic b;
      if (fmt[1])             b = rjbit(cur, i);
      else if (fmt == 2'd1)   b = (i == 0) ? sbit(prevw, cur_nclk - 1) : sbit(cur, i - 1);
      else                    b = sbit(cur, i);
      drive_bit(lvl, b);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sclk = 1'b0;
    repeat (4) @(negedge clk);
    n_got = 0;
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_cfg(input logic [1:0] f, input logic [1:0] d, input int nclk,
                         input int nbits, input bit lead_left, input string tag);
    int nfr = 3;
    logic lvl_l;
    logic [31:0] prevw = '1;
    fmt = f; depth = d; cur_nclk = nclk; cur_nbits = nbits;
    lvl_l = (f == 2'd1) ? 1'b0 : 1'b1;
    do_reset();
    if (lead_left) begin
      logic [31:0] orphan = gen();
      send_half(lvl_l, '1, prevw);     // partial half, discarded
      send_half(~lvl_l, orphan, '1);   // right with no left: no pulse
      prevw = orphan;
    end else begin
      send_half(~lvl_l, '1, prevw);    // partial half, discarded
    end
    for (int k = 0; k < nfr; k++) begin
      logic [31:0] lw = gen();
      logic [31:0] rw = gen();
      send_half(lvl_l, lw, prevw);
      send_half(~lvl_l, rw, lw);
      prevw = rw;
      exp_l[k] = expect_word(lw);
      exp_r[k] = expect_word(rw);
    end
    send_half(lvl_l, '1, prevw);       // closing half completes last right word
    repeat (20) @(negedge clk);
    check($sformatf("R8 pulse count %s", tag), 32'(n_got), 32'(nfr));
    for (int k = 0; k < nfr && k < n_got; k++) begin
      check($sformatf("R2 left %s frame%0d", tag, k), got_l[k], exp_l[k]);
      check($sformatf("R2 right %s frame%0d", tag, k), got_r[k], exp_r[k]);
    end
    check($sformatf("R7 hold left %s", tag), left_o, exp_l[nfr-1]);
    check($sformatf("R7 hold right %s", tag), right_o, exp_r[nfr-1]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset valid", 32'(valid_o), 32'd0);
    check("R9 reset left", left_o, 32'd0);
    check("R9 reset right", right_o, 32'd0);
    rst = 1'b0;

    // left-justified
    run_cfg(2'd0, 2'd0, 32, 32, 1'b0, "R3 full");
    run_cfg(2'd0, 2'd0, 40, 32, 1'b0, "R3 extra clocks");
    run_cfg(2'd0, 2'd0, 24, 24, 1'b0, "R6 lj short24");
    run_cfg(2'd0, 2'd0, 16, 16, 1'b0, "R6 lj short16");
    // I2S
    run_cfg(2'd1, 2'd0, 32, 32, 1'b0, "R4 full");
    run_cfg(2'd1, 2'd0, 40, 32, 1'b0, "R4 extra clocks");
    run_cfg(2'd1, 2'd0, 24, 24, 1'b0, "R6 i2s short24");
    run_cfg(2'd1, 2'd0, 17, 17, 1'b0, "R6 i2s short17");
    // right-justified, each depth
    for (int d = 0; d < 3; d++) begin
      run_cfg(2'd2, 2'(d), 32, 32, 1'b0, "R5 full word");
      run_cfg(2'd2, 2'(d), 32, 20, 1'b0, "R5 leading fill");
      run_cfg(2'd2, 2'(d), 12, 12, 1'b0, "R6 rj short12");
    end
    // alternate right-justified code and reserved depth code
    run_cfg(2'd3, 2'd3, 32, 32, 1'b0, "R1 alt code");
    run_cfg(2'd3, 2'd3, 12, 12, 1'b0, "R1 alt code short");
    // orphan right half after reset
    run_cfg(2'd0, 2'd0, 32, 32, 1'b1, "R8 orphan right");
    run_cfg(2'd2, 2'd1, 32, 24, 1'b1, "R8 orphan right rj");

    fin = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R7 got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule